// File: doc/BRIEF.md
# Lane Alignment Sequence Transmitter

This block is the link-layer front end on the transmit side of a multi-lane serial converter link. It sits ahead of an 8b/10b encoder. On every clock it hands each lane one octet and a flag that marks the octet as a control (K) character or a data character. After reset it sends the comma character /K/ on all lanes while the receiver holds the active-low `sync_n` line asserted. Once `sync_n` is released, it waits for the next multiframe boundary. It then plays out a four-multiframe initial alignment sequence and after that passes user octets straight through.

Framing comes from static configuration inputs: F is the number of octets per frame and K is the number of frames per multiframe. One octet is sent per clock, so a multiframe lasts MF = F*K cycles. MF must be between 8 and 2^CNT_W-1. An octet position counter runs freely from reset, wrapping every MF cycles, and it defines the multiframe boundaries. Every lane carries the same sequence in the same cycle.

A controller in state `ST_CGS`, `ST_ILAS` or `ST_DATA` decides what to send. The transitions are:
- `CGS_TO_ILAS`: `sync_n` is high in the last octet slot of a multiframe.
- `ILAS_TO_DATA`: the last slot of the fourth alignment multiframe is reached.
- `LINK_TO_CGS`: while in `ST_ILAS` or `ST_DATA`, `sync_n` has been low for 4*F consecutive cycles.

A shorter low pulse in those two states is reported as a receiver error and the controller stays in its state.

Top module: `lat_tx`

## Requirements
- R1: While `rst_n` is low, every lane outputs 0xBC with the control flag set, and `sod_strobe` and `err_report` are low.
- R2: In `ST_CGS` every lane outputs 0xBC (K28.5) with the control flag set.
- R3: The octet position counter starts at 0 after reset and wraps after MF-1. The alignment sequence starts at position 0, in the cycle after a cycle in which `sync_n` was high at position MF-1 while in `ST_CGS`.
- R4: In each alignment multiframe, position 0 is 0x1C (K28.0) and position MF-1 is 0x7C (K28.3), both flagged as control. The sequence lasts exactly four multiframes.
- R5: In the second alignment multiframe, position 1 is 0x9C (K28.4, control). Positions 2 to 6 are data octets in this order: device id, F-1, K-1, LANES-1, and the 8-bit modulo-256 sum of those four.
- R6: Every other alignment octet is a data octet whose value is its position within the multiframe, so the ramp restarts at 0 in each multiframe.
- R7: During `ST_CGS` and `ST_ILAS` all lanes carry identical octets and control flags.
- R8: In `ST_DATA`, lane n outputs `usr_data[8n+7:8n]` in the same cycle with the control flag clear.
- R9: `sod_strobe` is high for exactly the first cycle of `ST_DATA`.
- R10: Suppose `sync_n` goes low for between 1 and 4*F-1 consecutive cycles while in `ST_ILAS` or `ST_DATA`. Then `err_report` is high for one cycle, in the cycle after the first high sample of `sync_n`, and the state does not change.
- R11: When `sync_n` stays low for 4*F consecutive cycles while in `ST_ILAS` or `ST_DATA`, the next cycle is in `ST_CGS`, sending /K/, and no error report is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one octet per lane per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_n | input | 1 | Active-low synchronization request from the receiver (synchronous) |
| cfg_dev_id | input | 8 | Device identifier placed in the configuration record |
| cfg_oct_per_frame | input | 8 | F, octets per frame (at least 1) |
| cfg_frm_per_mf | input | 8 | K, frames per multiframe (at least 1) |
| usr_data | input | LANES*8 | User octets, lane n in bits 8n+7:8n |
| tx_octet | output | LANES*8 | Output octet per lane |
| tx_is_ctrl | output | LANES | Per-lane control-character flag |
| sod_strobe | output | 1 | One-cycle start-of-user-data strobe |
| err_report | output | 1 | One-cycle report of a short `sync_n` pulse |

## Verification
The octets, control flags and `sod_strobe` are decoded from registered state, so they change in the cycle after the clock edge that samples the triggering `sync_n` level or counter position. `usr_data` reaches `tx_octet` with no delay. `err_report` rises one edge after the first high sample of `sync_n`. The bench runs a cycle-level expectation model that advances on each rising edge, using the inputs held across that edge. It drives new inputs shortly after the rising edge and compares every output on the falling edge, so each result is checked in exactly the cycle it is due. Pulses of exactly 4*F-1 and 4*F low cycles are placed deliberately in every configuration.

// File: rtl/lat_pkg.sv
package lat_pkg;

    typedef enum logic [1:0] {
        ST_CGS  = 2'd0,
        ST_ILAS = 2'd1,
        ST_DATA = 2'd2
    } tx_state_e;

    localparam logic [7:0] K_COMMA     = 8'hBC;
    localparam logic [7:0] K_MF_FIRST  = 8'h1C;
    localparam logic [7:0] K_MF_LAST   = 8'h7C;
    localparam logic [7:0] K_CFG_MARK  = 8'h9C;
    localparam int         ILAS_MFS    = 4;

endpackage

// File: rtl/lat_mf_counter.sv
module lat_mf_counter #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] mf_len,
    output logic [CNT_W-1:0] oct_pos,
    output logic             mf_last
);

    logic [CNT_W-1:0] last_pos;

    assign last_pos = mf_len - 1'b1;
    assign mf_last  = (oct_pos == last_pos);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oct_pos <= '0;
        end else if (oct_pos >= last_pos) begin
            oct_pos <= '0;
        end else begin
            oct_pos <= oct_pos + 1'b1;
        end
    end

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        oct_pos < mf_len); // R3

endmodule

// File: rtl/lat_sync_mon.sv
module lat_sync_mon #(
    parameter int LOW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_n,
    input  logic             link_up,
    input  logic [LOW_W-1:0] thresh,
    output logic             reinit_req,
    output logic             err_report
);

    logic [LOW_W-1:0] low_cnt;

    assign reinit_req = !sync_n && link_up && (low_cnt == thresh - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt    <= '0;
            err_report <= 1'b0;
        end else begin
            err_report <= sync_n && link_up && (low_cnt != '0);
            if (sync_n) begin
                low_cnt <= '0;
            end else if (low_cnt != thresh) begin
                low_cnt <= low_cnt + 1'b1;
            end
        end
    end

    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_report |=> !err_report); // R10

endmodule

// File: rtl/lat_octet_gen.sv
module lat_octet_gen
    import lat_pkg::*;
#(
    parameter int LANES = 2,
    parameter int CNT_W = 10,
    parameter int MFI_W = 2
) (
    input  logic             in_ilas,
    input  logic [MFI_W-1:0] mf_idx,
    input  logic [CNT_W-1:0] pos,
    input  logic [CNT_W-1:0] mf_len,
    input  logic [7:0]       cfg_dev_id,
    input  logic [7:0]       cfg_f,
    input  logic [7:0]       cfg_k,
    output logic [7:0]       oct,
    output logic             ctrl
);

    logic [7:0] f_m1, k_m1, l_m1, chk;
    logic       cfg_mf;

    assign f_m1   = cfg_f - 8'd1;
    assign k_m1   = cfg_k - 8'd1;
    assign l_m1   = 8'(LANES - 1);
    assign chk    = cfg_dev_id + f_m1 + k_m1 + l_m1;
    assign cfg_mf = (mf_idx == MFI_W'(1));

    always_comb begin
        oct  = pos[7:0];
        ctrl = 1'b0;
        if (!in_ilas) begin
            oct  = K_COMMA;
            ctrl = 1'b1;
        end else if (pos == '0) begin
            oct  = K_MF_FIRST;
            ctrl = 1'b1;
        end else if (pos == mf_len - 1'b1) begin
            oct  = K_MF_LAST;
            ctrl = 1'b1;
        end else if (cfg_mf && pos <= CNT_W'(6)) begin
            unique case (pos[2:0])
                3'd1: begin oct = K_CFG_MARK; ctrl = 1'b1; end
                3'd2: oct = cfg_dev_id;
                3'd3: oct = f_m1;
                3'd4: oct = k_m1;
                3'd5: oct = l_m1;
                default: oct = chk;
            endcase
        end
    end

endmodule

// File: rtl/lat_tx.sv
module lat_tx
    import lat_pkg::*;
#(
    parameter int LANES = 2,
    parameter int CNT_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sync_n,
    input  logic [7:0]         cfg_dev_id,
    input  logic [7:0]         cfg_oct_per_frame,
    input  logic [7:0]         cfg_frm_per_mf,
    input  logic [LANES*8-1:0] usr_data,
    output logic [LANES*8-1:0] tx_octet,
    output logic [LANES-1:0]   tx_is_ctrl,
    output logic               sod_strobe,
    output logic               err_report
);

    localparam int LOW_W = 10;
    localparam int MFI_W = $clog2(ILAS_MFS);

    tx_state_e        state, nxt;
    logic [MFI_W-1:0] mf_idx;
    logic             was_data;
    logic [CNT_W-1:0] mf_len;
    logic [CNT_W-1:0] oct_pos;
    logic             mf_last;
    logic             reinit_req;
    logic [LOW_W-1:0] thresh;
    logic [7:0]       seq_oct;
    logic             seq_ctrl;

    assign mf_len = CNT_W'(cfg_oct_per_frame) * CNT_W'(cfg_frm_per_mf);
    assign thresh = {cfg_oct_per_frame, 2'b00};

    lat_mf_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .mf_len  (mf_len),
        .oct_pos (oct_pos),
        .mf_last (mf_last)
    );

    lat_sync_mon #(.LOW_W(LOW_W)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_n     (sync_n),
        .link_up    (state != ST_CGS),
        .thresh     (thresh),
        .reinit_req (reinit_req),
        .err_report (err_report)
    );

    lat_octet_gen #(.LANES(LANES), .CNT_W(CNT_W), .MFI_W(MFI_W)) u_gen (
        .in_ilas    (state == ST_ILAS),
        .mf_idx     (mf_idx),
        .pos        (oct_pos),
        .mf_len     (mf_len),
        .cfg_dev_id (cfg_dev_id),
        .cfg_f      (cfg_oct_per_frame),
        .cfg_k      (cfg_frm_per_mf),
        .oct        (seq_oct),
        .ctrl       (seq_ctrl)
    );

    // State register with multiframe index and data-entry history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_CGS;
            mf_idx   <= '0;
            was_data <= 1'b0;
        end else begin
            state    <= nxt;
            was_data <= (state == ST_DATA);
            if (state != ST_ILAS) begin
                mf_idx <= '0;
            end else if (mf_last) begin
                mf_idx <= mf_idx + 1'b1;
            end
        end
    end

    // Transitions: CGS_TO_ILAS, ILAS_TO_DATA, LINK_TO_CGS
    always_comb begin
        nxt = state;
        unique case (state)
            ST_CGS:  if (sync_n && mf_last) nxt = ST_ILAS;
            ST_ILAS: begin
                if (reinit_req) begin
                    nxt = ST_CGS;
                end else if (mf_last && mf_idx == MFI_W'(ILAS_MFS - 1)) begin
                    nxt = ST_DATA;
                end
            end
            ST_DATA: if (reinit_req) nxt = ST_CGS;
            default: nxt = ST_CGS;
        endcase
    end

    // Outputs
    always_comb begin
        sod_strobe = (state == ST_DATA) && !was_data;
    end

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        always_comb begin
            if (state == ST_DATA) begin
                tx_octet[ln*8 +: 8] = usr_data[ln*8 +: 8];
                tx_is_ctrl[ln]      = 1'b0;
            end else begin
                tx_octet[ln*8 +: 8] = seq_oct;
                tx_is_ctrl[ln]      = seq_ctrl;
            end
        end
    end

    AST_ILAS_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ILAS && $past(state) == ST_CGS) |-> (oct_pos == '0)); // R3

    AST_DATA_AFTER_FOURTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && $past(state) == ST_ILAS)
            |-> ($past(mf_idx) == MFI_W'(ILAS_MFS - 1) && $past(mf_last))); // R4

    AST_SOD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        sod_strobe |=> !sod_strobe); // R9

    AST_REINIT_ON_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CGS && $past(state) != ST_CGS) |-> !$past(sync_n)); // R11

endmodule

// File: tb/tb_lat_tx.sv
module tb_lat_tx;

    localparam int LANES = 2;
    localparam int CNT_W = 10;
    localparam int DW    = LANES * 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sync_n = 1'b0;
    logic [7:0]    cfg_dev_id = 8'h00;
    logic [7:0]    cfg_f = 8'd1;
    logic [7:0]    cfg_k = 8'd8;
    logic [DW-1:0] usr_data = '0;
    logic [DW-1:0] tx_octet;
    logic [LANES-1:0] tx_is_ctrl;
    logic          sod_strobe;
    logic          err_report;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expectation model
    int m_state = 0, m_prev = 0, m_oct = 0, m_mf = 0, m_low = 0;
    bit m_err = 1'b0, m_reinit = 1'b0;
    int cF = 1, cK = 8, cMF = 8;

    always #10 clk = ~clk;

    lat_tx #(.LANES(LANES), .CNT_W(CNT_W)) dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .sync_n            (sync_n),
        .cfg_dev_id        (cfg_dev_id),
        .cfg_oct_per_frame (cfg_f),
        .cfg_frm_per_mf    (cfg_k),
        .usr_data          (usr_data),
        .tx_octet          (tx_octet),
        .tx_is_ctrl        (tx_is_ctrl),
        .sod_strobe        (sod_strobe),
        .err_report        (err_report)
    );

    always @(posedge clk) begin
        int ns, nmf;
        bit rq, en;
        if (!rst_n) begin
            m_state = 0; m_prev = 0; m_oct = 0; m_mf = 0; m_low = 0;
            m_err = 1'b0; m_reinit = 1'b0;
        end else begin
            ns  = m_state;
            nmf = m_mf;
            rq  = !sync_n && (m_state != 0) && (m_low == 4 * cF - 1);
            en  = sync_n && (m_low != 0) && (m_state != 0);
            case (m_state)
                0: if (sync_n && m_oct == cMF - 1) begin ns = 1; nmf = 0; end
                1: begin
                    if (rq) ns = 0;
                    else if (m_oct == cMF - 1) begin
                        if (m_mf == 3) ns = 2; else nmf = m_mf + 1;
                    end
                end
                default: if (rq) ns = 0;
            endcase
            if (rq) m_reinit = 1'b1;
            else if (ns != 0) m_reinit = 1'b0;
            m_low  = sync_n ? 0 : ((m_low < 4 * cF) ? m_low + 1 : m_low);
            m_err  = en;
            m_oct  = (m_oct >= cMF - 1) ? 0 : m_oct + 1;
            m_prev = m_state;
            m_state = ns;
            m_mf   = nmf;
        end
    end

    function automatic logic [8:0] exp_lane(int lane);
        logic [7:0] fm1, km1, lm1;
        fm1 = cfg_f - 8'd1;
        km1 = cfg_k - 8'd1;
        lm1 = 8'(LANES - 1);
        if (m_state == 0) return {1'b1, 8'hBC};
        if (m_state == 2) return {1'b0, usr_data[lane*8 +: 8]};
        if (m_oct == 0)        return {1'b1, 8'h1C};
        if (m_oct == cMF - 1)  return {1'b1, 8'h7C};
        if (m_mf == 1) begin
            case (m_oct)
                1: return {1'b1, 8'h9C};
                2: return {1'b0, cfg_dev_id};
                3: return {1'b0, fm1};
                4: return {1'b0, km1};
                5: return {1'b0, lm1};
                6: return {1'b0, 8'(cfg_dev_id + fm1 + km1 + lm1)};
                default: ;
            endcase
        end
        return {1'b0, 8'(m_oct)};
    endfunction

    function automatic string oct_tag();
        if (m_state == 0) return m_reinit ? "R11" : "R2";
        if (m_state == 2) return "R8";
        if (m_oct == 0 && m_mf == 0) return "R3";
        if (m_oct == 0 || m_oct == cMF - 1) return "R4";
        if (m_mf == 1 && m_oct <= 6) return "R5";
        return "R6";
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                for (int l = 0; l < LANES; l++)
                    chk({tx_is_ctrl[l], tx_octet[l*8 +: 8]} == 9'h1BC, "R1",
                        {tx_is_ctrl[l], tx_octet[l*8 +: 8]}, 9'h1BC);
                chk(!sod_strobe && !err_report, "R1", {sod_strobe, err_report}, 0);
            end else begin
                for (int l = 0; l < LANES; l++) begin
                    logic [8:0] e;
                    e = exp_lane(l);
                    chk({tx_is_ctrl[l], tx_octet[l*8 +: 8]} == e, oct_tag(),
                        {tx_is_ctrl[l], tx_octet[l*8 +: 8]}, e);
                    if (m_state != 2 && l > 0)
                        chk({tx_is_ctrl[l], tx_octet[l*8 +: 8]} == {tx_is_ctrl[0], tx_octet[7:0]},
                            "R7", {tx_is_ctrl[l], tx_octet[l*8 +: 8]},
                            {tx_is_ctrl[0], tx_octet[7:0]});
                end
                chk(sod_strobe == (m_state == 2 && m_prev != 2), "R9",
                    sod_strobe, (m_state == 2 && m_prev != 2));
                chk(err_report == m_err, "R10", err_report, m_err);
            end
        end
    end

    task automatic cyc(bit s);
        @(posedge clk);
        #1;
        sync_n   = s;
        usr_data = DW'($urandom);
    endtask

    task automatic run(int f, int k);
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        sync_n = 1'b0;
        cF = f; cK = k; cMF = f * k;
        cfg_f = 8'(f);
        cfg_k = 8'(k);
        cfg_dev_id = 8'($urandom);
        repeat (3) cyc(1'b0);
        @(posedge clk);
        #1;
        rst_n = 1'b1;
        repeat (5 + $urandom % 40) cyc(1'b0);
        repeat (6 * cMF) cyc(1'b1);
        repeat (4 * f - 1) cyc(1'b0);           // longest error pulse, R10
        repeat (20) cyc(1'b1);
        repeat (4 * f) cyc(1'b0);               // shortest reinit pulse, R11
        repeat (6 * cMF) cyc(1'b1);
        repeat (8) begin
            repeat (1 + $urandom % (4 * f + 3)) cyc(1'b0);
            repeat (5 + $urandom % (2 * cMF)) cyc(1'b1);
        end
    endtask

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        run(1, 8);
        run(2, 4);
        run(4, 16);
        repeat (7) begin
            int f, k;
            f = 1 + $urandom % 8;
            k = 1 + $urandom % 16;
            while (f * k < 8) k++;
            run(f, k);
        end
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule